// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter with Compare and PWM

This block is an 8-bit timer/counter driven from one system clock. A 3-bit rate field picks either a halt or one of seven division ratios taken from a free-running 10-bit prescaler. Alternatively, the counter can advance on rising or falling edges of an external pin. The pin is passed through a two-flop synchronizer before edge detection. The pin's value is counted whatever drives it, so software that drives the pad as an output can step the counter itself.

Software reaches the block through a write-only register bus with four addresses. The count, compare value, flags and PWM level are also presented continuously on output ports. The block has two counting modes:

- **Normal mode:** the counter counts up and wraps, raising a sticky overflow flag.
- **PWM mode:** the counter sweeps up to 0xFF and back down to 0x00. An output pin is cleared on a match while rising and set on a match while falling. The compare value used in this mode is double-buffered and is refreshed only at the top of the sweep.

Top module: `ticktimer8`

## Requirements
- R1: After reset the count, the compare value, both flags and `pwm_o` are all 0.
- R2: With rate field `ctl[2:0]`=000 and `ctl[4]`=0 the timer is halted and the count holds its value.
- R3: The control register is at address 0, with the rate field in bits [2:0]. Codes 001 to 111 select a tick every 1, 8, 32, 64, 128, 256 and 1024 clocks. While halted the prescaler is held at zero. After the rate is written from a halted state, the first increment lands N edges after the write edge.
- R4: A write to address 1 loads the count. Counting continues from that value on the next tick. A write that coincides with a tick wins over the tick.
- R5: In normal mode (`ctl[3]`=0) each tick adds one. On the step from 0xFF to 0x00 the overflow flag (`flags_o[0]`) is set.
- R6: A tick taken while the count equals the active compare value sets the match flag (`flags_o[1]`).
- R7: Both flags are sticky. Writing address 3 clears each flag whose data bit is 1 (bit0 overflow, bit1 match) and leaves the other flags untouched. A new event wins over a clear in the same cycle.
- R8: With `ctl[4]`=1 the counter ticks on edges of `ext_pin`: rising edges when `ctl[5]`=0, falling edges when `ctl[5]`=1. A pin change set up before edge k shows up in the count after edge k+2.
- R9: In PWM mode (`ctl[3]`=1) a tick at 0xFF gives 0xFE and a tick at 0x00 on the way down gives 0x01. The bottom turn sets the overflow flag.
- R10: In PWM mode `pwm_o` clears on a match while counting up and sets on a match while counting down. A compare value of 0x00 holds it low and 0xFF holds it high. In normal mode `pwm_o` is 0.
- R11: In PWM mode a write to the compare register (address 2) is stored and read back on `compare_o` at once. It becomes the active compare only at the tick taken at count 0xFF while counting up. In normal mode the written value is used directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 ctrl, 1 count, 2 compare, 3 flag clear) |
| bus_wdata | input | 8 | Write data |
| ext_pin | input | 1 | External count pin (pad value) |
| count_o | output | 8 | Current count |
| compare_o | output | 8 | Last written compare value |
| flags_o | output | 2 | Sticky flags: bit0 overflow, bit1 match |
| pwm_o | output | 1 | PWM output |

## Verification
Bus writes land on the clock edge they straddle. Count, flags and `pwm_o` are registered, so with the internal rate of one tick per clock each result shows up one edge after the tick that causes it. From a halted start, a divide-by-N rate gives its first increment N edges after the write. A pin change reaches the count three edges after it is set up. Every scenario drives inputs on the falling edge and counts falling edges from a known write, so each check samples exactly after the edge where the value is first due. The check one edge earlier confirms the value had not yet changed.

// File: rtl/ticktimer8_pkg.sv
package ticktimer8_pkg;
  localparam int CNT_W = 8;
  localparam int PRE_W = 10;

  localparam logic [1:0] ADR_CTL   = 2'd0;
  localparam logic [1:0] ADR_COUNT = 2'd1;
  localparam logic [1:0] ADR_CMP   = 2'd2;
  localparam logic [1:0] ADR_FLAGS = 2'd3;

  // low prescaler bits that must all be one for a tick at this rate code
  function automatic logic [PRE_W-1:0] tap_mask(input logic [2:0] rate);
    case (rate)
      3'd2:    tap_mask = PRE_W'(7);
      3'd3:    tap_mask = PRE_W'(31);
      3'd4:    tap_mask = PRE_W'(63);
      3'd5:    tap_mask = PRE_W'(127);
      3'd6:    tap_mask = PRE_W'(255);
      3'd7:    tap_mask = PRE_W'(1023);
      default: tap_mask = '0;
    endcase
  endfunction

  function automatic logic rate_tick(input logic [PRE_W-1:0] pre, input logic [2:0] rate);
    rate_tick = (rate != 3'd0) && ((pre & tap_mask(rate)) == tap_mask(rate));
  endfunction

  // one step of the up/down sweep; returns {next_up, next_count}
  function automatic logic [CNT_W:0] sweep_step(input logic [CNT_W-1:0] c, input logic up);
    if (up) begin
      if (c == '1) sweep_step = {1'b0, c - 1'b1};
      else         sweep_step = {1'b1, c + 1'b1};
    end else begin
      if (c == '0) sweep_step = {1'b1, c + 1'b1};
      else         sweep_step = {1'b0, c - 1'b1};
    end
  endfunction
endpackage

// File: rtl/ticktimer8_prescale.sv
module ticktimer8_prescale
  import ticktimer8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             pre_q <= '0;
    else if (rate == 3'd0)  pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  assign tick_o = rate_tick(pre_q, rate);
endmodule

// File: rtl/ticktimer8_edge.sv
module ticktimer8_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_o
);
  logic [SYNC:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC-1:0], pin};
  end

  logic now_v, was_v;
  assign now_v  = sh_q[SYNC-1];
  assign was_v  = sh_q[SYNC];
  assign edge_o = fall_sel ? (was_v & ~now_v) : (now_v & ~was_v);
endmodule

// File: rtl/ticktimer8_core.sv
module ticktimer8_core
  import ticktimer8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sweep,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_eff,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             wrap_ev,
  output logic             match_ev,
  output logic             top_ev
);
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic [CNT_W:0]   step;
  logic             adv;

  assign adv      = tick && !load;
  assign step     = sweep_step(cnt_q, up_q);
  assign match_ev = adv && (cnt_q == cmp_eff);
  assign top_ev   = adv && sweep && up_q && (cnt_q == '1);
  assign wrap_ev  = adv && (sweep ? (!up_q && cnt_q == '0) : (cnt_q == '1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      if (load) cnt_q <= load_val;
      else if (tick) cnt_q <= sweep ? step[CNT_W-1:0] : cnt_q + 1'b1;
      if (!sweep)   up_q <= 1'b1;
      else if (adv) up_q <= step[CNT_W];
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;
endmodule

// File: rtl/ticktimer8.sv
module ticktimer8
  import ticktimer8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic             ext_pin,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] compare_o,
  output logic [1:0]       flags_o,
  output logic             pwm_o
);
  logic [5:0]       ctl_q;
  logic [CNT_W-1:0] cmp_buf_q, cmp_act_q, cmp_eff;
  logic [1:0]       flag_q;
  logic             pwm_q;

  logic [2:0] rate;
  logic       sweep, ext_on, ext_fall, stopped;
  assign rate     = ctl_q[2:0];
  assign sweep    = ctl_q[3];
  assign ext_on   = ctl_q[4];
  assign ext_fall = ctl_q[5];
  assign stopped  = (rate == 3'd0) && !ext_on;

  logic ctl_wr, cnt_wr, cmp_wr, flg_wr;
  assign ctl_wr = bus_we && bus_addr == ADR_CTL;
  assign cnt_wr = bus_we && bus_addr == ADR_COUNT;
  assign cmp_wr = bus_we && bus_addr == ADR_CMP;
  assign flg_wr = bus_we && bus_addr == ADR_FLAGS;

  logic [1:0] flag_clr;
  assign flag_clr = flg_wr ? bus_wdata[1:0] : 2'b00;

  logic pre_tick, pin_edge, tick;
  ticktimer8_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .rate(rate), .tick_o(pre_tick)
  );
  ticktimer8_edge #(.SYNC(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .fall_sel(ext_fall), .edge_o(pin_edge)
  );
  assign tick = ext_on ? pin_edge : pre_tick;

  logic [CNT_W-1:0] cnt;
  logic             up, wrap_ev, match_ev, top_ev;
  ticktimer8_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sweep(sweep),
    .load(cnt_wr), .load_val(bus_wdata), .cmp_eff(cmp_eff),
    .cnt_o(cnt), .up_o(up), .wrap_ev(wrap_ev), .match_ev(match_ev), .top_ev(top_ev)
  );

  assign cmp_eff = sweep ? cmp_act_q : cmp_buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      cmp_buf_q <= '0;
      cmp_act_q <= '0;
      flag_q    <= '0;
      pwm_q     <= 1'b1;
    end else begin
      if (ctl_wr) ctl_q <= bus_wdata[5:0];
      if (cmp_wr) cmp_buf_q <= bus_wdata;
      if (!sweep || top_ev) cmp_act_q <= cmp_buf_q;
      flag_q[0] <= (flag_q[0] & ~flag_clr[0]) | wrap_ev;
      flag_q[1] <= (flag_q[1] & ~flag_clr[1]) | match_ev;
      if (!sweep)        pwm_q <= 1'b1;
      else if (match_ev) pwm_q <= !up;
    end
  end

  assign count_o   = cnt;
  assign compare_o = cmp_buf_q;
  assign flags_o   = flag_q;
  assign pwm_o     = sweep && ((cmp_eff == '1) || ((cmp_eff != '0) && pwm_q));
endmodule

// File: rtl/ticktimer8_chk.sv
module ticktimer8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         cnt_wr,
  input logic         sweep,
  input logic         stopped,
  input logic [W-1:0] cnt,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cmp_eff,
  input logic [1:0]   flags,
  input logic [1:0]   flag_clr
);
  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped && !cnt_wr |=> $stable(cnt));
  // R4
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(wdata));
  // R5
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_wr && !sweep && cnt == '1 |=> cnt == '0 && flags[0]);
  // R6
  match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_wr && cnt == cmp_eff |=> flags[1]);
  // R7
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] && !flag_clr[0] |=> flags[0]);
  // R9
  sweep_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep && tick && !cnt_wr && cnt == '1 |=> cnt == {{(W-1){1'b1}}, 1'b0});
endmodule

bind ticktimer8 ticktimer8_chk #(.W(8)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .sweep(sweep),
  .stopped(stopped), .cnt(cnt), .wdata(bus_wdata), .cmp_eff(cmp_eff),
  .flags(flag_q), .flag_clr(flag_clr)
);

// File: tb/test_ticktimer8.sv
module test_ticktimer8;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic       ext_pin = 1'b0;
  logic [7:0] count_o, compare_o;
  logic [1:0] flags_o;
  logic       pwm_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ticktimer8 i_ticktimer8 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ext_pin(ext_pin), .count_o(count_o),
    .compare_o(compare_o), .flags_o(flags_o), .pwm_o(pwm_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ratio(input int code);
    case (code)
      1: ratio = 1;    2: ratio = 8;    3: ratio = 32;  4: ratio = 64;
      5: ratio = 128;  6: ratio = 256;  default: ratio = 1024;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 count", count_o, 0);
    chk("R1 compare", compare_o, 0);
    chk("R1 flags", flags_o, 0);
    chk("R1 pwm", pwm_o, 0);
  endtask

  task automatic t_halt();
    wr(1, 8'h55);
    adv(20);
    chk("R2 halted count holds", count_o, 8'h55);
  endtask

  task automatic t_rates();
    for (int code = 1; code <= 7; code++) begin
      wr(0, 0); wr(1, 0); wr(0, 8'(code));
      if (ratio(code) > 1) adv(ratio(code) - 1);
      chk($sformatf("R3 rate %0d before tick", code), count_o, 0);
      adv(1);
      chk($sformatf("R3 rate %0d first tick", code), count_o, 1);
    end
    wr(0, 0);
  endtask

  task automatic t_load();
    wr(0, 0); wr(1, 0); wr(0, 1);
    adv(3);
    chk("R4 running count", count_o, 3);
    wr(1, 8'h40);
    chk("R4 write wins over tick", count_o, 8'h40);
    adv(1);
    chk("R4 continue from written", count_o, 8'h41);
    wr(0, 0);
  endtask

  task automatic t_wrap();
    wr(0, 0); wr(1, 8'hFD); wr(3, 3); wr(0, 1);
    adv(2);
    chk("R5 count at top", count_o, 8'hFF);
    chk("R5 no overflow yet", flags_o[0], 0);
    adv(1);
    chk("R5 wrapped", count_o, 0);
    chk("R5 overflow set", flags_o[0], 1);
    wr(0, 0);
  endtask

  task automatic t_match();
    wr(0, 0); wr(2, 8'h22); wr(1, 8'h20); wr(3, 3); wr(0, 1);
    adv(2);
    chk("R6 no match yet", flags_o[1], 0);
    adv(1);
    chk("R6 match flag", flags_o[1], 1);
    wr(0, 0);
  endtask

  task automatic t_flags();
    wr(3, 0);
    chk("R7 zero write keeps match", flags_o[1], 1);
    wr(3, 1);
    chk("R7 bit0 clear keeps match", flags_o[1], 1);
    wr(3, 2);
    chk("R7 bit1 clears match", flags_o[1], 0);
  endtask

  task automatic t_ext();
    wr(0, 0); wr(1, 0); wr(0, 8'h10);
    adv(4);
    chk("R8 idle pin no count", count_o, 0);
    @(negedge clk); ext_pin = 1'b1;
    adv(2);
    chk("R8 rise not yet", count_o, 0);
    adv(1);
    chk("R8 rise counted", count_o, 1);
    @(negedge clk); ext_pin = 1'b0;
    adv(5);
    chk("R8 fall ignored in rise mode", count_o, 1);
    wr(0, 8'h30);
    @(negedge clk); ext_pin = 1'b1;
    adv(5);
    chk("R8 rise ignored in fall mode", count_o, 1);
    @(negedge clk); ext_pin = 1'b0;
    adv(2);
    chk("R8 fall not yet", count_o, 1);
    adv(1);
    chk("R8 fall counted", count_o, 2);
    wr(0, 0);
  endtask

  task automatic t_sweep();
    wr(0, 0); wr(2, 8'h80); wr(1, 8'h7E); wr(3, 3); wr(0, 8'h09);
    adv(2);
    chk("R10 high below compare", pwm_o, 1);
    adv(1);
    chk("R10 cleared on up match", pwm_o, 0);
    adv(126);
    chk("R9 reached top", count_o, 8'hFF);
    adv(1);
    chk("R9 turn at top", count_o, 8'hFE);
    adv(126);
    chk("R10 low before down match", pwm_o, 0);
    adv(1);
    chk("R10 set on down match", pwm_o, 1);
    chk("R9 counting down", count_o, 8'h7F);
    adv(127);
    chk("R9 reached bottom", count_o, 0);
    chk("R9 no overflow before turn", flags_o[0], 0);
    adv(1);
    chk("R9 turn at bottom", count_o, 1);
    chk("R9 bottom sets overflow", flags_o[0], 1);
    wr(0, 0);
  endtask

  task automatic t_buffer();
    wr(0, 0); wr(2, 8'h80); wr(1, 8'h10); wr(0, 8'h09);
    wr(2, 8'h40);
    chk("R11 readback immediate", compare_o, 8'h40);
    chk("R11 count at write", count_o, 8'h12);
    adv(110);
    chk("R11 old compare still active", pwm_o, 1);
    adv(1);
    chk("R11 up match at old compare", pwm_o, 0);
    adv(127);
    chk("R11 turned at top", count_o, 8'hFE);
    adv(190);
    chk("R11 at new compare", count_o, 8'h40);
    chk("R11 still low", pwm_o, 0);
    adv(1);
    chk("R11 new compare used after top", pwm_o, 1);
    wr(0, 0);
  endtask

  task automatic t_const();
    wr(0, 0);
    chk("R10 low in normal mode", pwm_o, 0);
    wr(2, 8'h00); wr(0, 8'h08);
    chk("R10 compare 00 low", pwm_o, 0);
    wr(0, 0); wr(2, 8'hFF); wr(0, 8'h08);
    chk("R10 compare FF high", pwm_o, 1);
    wr(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halt();
    t_rates();
    t_load();
    t_wrap();
    t_match();
    t_flags();
    t_ext();
    t_sweep();
    t_buffer();
    t_const();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule